// File: doc/BRIEF.md
# Segmented Instruction Prefetch Queue

This block is the instruction-fetch half of a real-mode bus interface for an 8086-class core. It keeps a private 16-bit prefetch offset, separate from the architectural instruction pointer. It adds that offset to the code segment shifted left by four to form a physical byte address. It passes the address through an address-line-20 gate, issues one byte read at a time on a simple memory port, and pushes each returned byte into a small FIFO. The execution side pops opcode bytes from that FIFO and sees the instruction pointer of the byte at the head.

A flush, raised on any jump, call, interrupt or code segment reload, empties the queue and reloads both the prefetch offset and the consumer instruction pointer from a new value. External protection logic can lower a fetch-permit input. While it is low, no read is issued and no fault is raised: filling simply pauses.

Streams use valid/ready. A memory request transfers on a cycle where `mem_req_valid` and `mem_req_ready` are both high, and the prefetch offset advances only on that transfer. The request is combinational: it drops whenever permit falls, a flush arrives or a read is outstanding, so the memory side must sample the address only on a transfer cycle. The response has no ready because the queue slot is reserved when the read is issued. An opcode byte transfers when `op_valid` and `op_ready` are both high, and the consumer may hold `op_ready` high while the queue is empty.

Top module: `seg_prefetch_unit`

## Requirements
- R1: The read address is ({code_seg, 4'b0000} + prefetch offset) in 21 bits. When `a20_open` is 0, bit 20 of that address is forced to 0; when 1, the sum is passed unchanged.
- R2: The prefetch offset and the consumer instruction pointer are 16 bits and wrap from FFFFh to 0000h, so fetching continues at the start of the same segment.
- R3: A flush empties the queue and loads both the prefetch offset and `op_ip` from `flush_ip`. The first byte delivered afterwards is the one at `flush_ip`.
- R4: While `fetch_ok` is 0, `mem_req_valid` stays 0, so no read is issued.
- R5: While the queue is empty, `op_valid` is 0 and `op_ip` does not change, even with `op_ready` high.
- R6: Bytes are delivered in address order, and each pop transfer advances `op_ip` by exactly one.
- R7: At most one read is outstanding. Queued bytes plus outstanding reads never exceed DEPTH (6), so with no pops exactly 6 reads are issued after a flush.
- R8: A read that is outstanding when a flush occurs is discarded when it returns, including one that returns in the flush cycle itself.
- R9: In a cycle with `flush` high, `op_valid` is 0, so a pop attempted in that cycle does not transfer and does not advance `op_ip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_seg | input | 16 | Current code segment value |
| a20_open | input | 1 | 1 passes address bit 20, 0 forces it to zero |
| flush | input | 1 | Empty queue and reload pointers |
| flush_ip | input | 16 | New instruction pointer for a flush |
| fetch_ok | input | 1 | Permission to issue prefetch reads |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 21 | Physical byte address of the read |
| mem_rsp_valid | input | 1 | Read data returning |
| mem_rsp_data | input | 8 | Returned byte |
| op_valid | output | 1 | Opcode byte available |
| op_ready | input | 1 | Consumer takes the byte |
| op_data | output | 8 | Opcode byte at the queue head |
| op_ip | output | 16 | Instruction pointer of the head byte |

## Verification
On every cycle, the assertions check four things. The queue never overflows or underflows. No read is requested while permit is low or while a read is outstanding. `op_ip` holds unless a pop or a flush happens, and it steps by one on a pop. A flush loads `op_ip`. Only the bench scenarios can show the data-path properties: correct address formation and A20 masking, offset wrap inside the segment, the exact count of six reads, and that a stale in-flight byte never reaches the consumer. They do this by comparing delivered bytes against an address-derived memory pattern.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [0:0] {
    FS_IDLE = 1'b0,
    FS_BUSY = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 21,
  parameter int GATE_BIT  = 20
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic             gate_open,
  output logic [PA_W-1:0]  phys
);
  logic [PA_W-1:0] seg_ext;
  logic [PA_W-1:0] off_ext;
  logic [PA_W-1:0] raw;

  always_comb begin
    seg_ext = PA_W'(seg) << SEG_SHIFT;
    off_ext = PA_W'(off);
    raw     = seg_ext + off_ext;
  end

  generate
    if (GATE_BIT < PA_W) begin : g_gate
      localparam logic [PA_W-1:0] GATE_MASK = ~(PA_W'(1) << GATE_BIT);
      always_comb phys = gate_open ? raw : (raw & GATE_MASK);
    end else begin : g_nogate
      always_comb phys = raw;
    end
  endgenerate
endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign head_data = mem[rd_ptr];

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clear) |-> (count < CNT_W'(DEPTH)));
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
  import pfq_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [OFF_W-1:0] flush_ip,
  input  logic             fetch_ok,
  input  logic [CNT_W-1:0] q_count,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic [OFF_W-1:0] pf_off,
  output logic             push
);
  fetch_state_e     state;
  logic             drop;
  logic             accept;
  logic [CNT_W:0]   used;
  logic             space;

  always_comb begin
    used      = {1'b0, q_count} + (CNT_W+1)'(state == FS_BUSY);
    space     = used < (CNT_W+1)'(DEPTH);
    req_valid = (state == FS_IDLE) && fetch_ok && !flush && space;
    accept    = req_valid && req_ready;
    push      = rsp_valid && (state == FS_BUSY) && !drop && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_off <= '0;
      state  <= FS_IDLE;
      drop   <= 1'b0;
    end else begin
      if (flush)       pf_off <= flush_ip;
      else if (accept) pf_off <= pf_off + 1'b1;

      if (accept)                                  state <= FS_BUSY;
      else if (state == FS_BUSY && rsp_valid)      state <= FS_IDLE;

      if (state == FS_BUSY && rsp_valid)           drop <= 1'b0;
      else if (flush && state == FS_BUSY)          drop <= 1'b1;
    end
  end

  // R4
  no_fetch_unpermitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ok |-> !req_valid);
  // R7
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_valid);
endmodule

// File: rtl/seg_prefetch_unit.sv
module seg_prefetch_unit #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 21,
  parameter int GATE_BIT  = 20,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_W-1:0]  code_seg,
  input  logic              a20_open,
  input  logic              flush,
  input  logic [OFF_W-1:0]  flush_ip,
  input  logic              fetch_ok,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [DATA_W-1:0] op_data,
  output logic [OFF_W-1:0]  op_ip
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [OFF_W-1:0] pf_off;
  logic             push;
  logic             pop;
  logic [CNT_W-1:0] q_count;

  pfq_fetch_ctl #(.OFF_W(OFF_W), .DEPTH(DEPTH)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .flush_ip (flush_ip),
    .fetch_ok (fetch_ok),
    .q_count  (q_count),
    .req_valid(mem_req_valid),
    .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid),
    .pf_off   (pf_off),
    .push     (push)
  );

  pfq_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT),
    .PA_W(PA_W), .GATE_BIT(GATE_BIT)
  ) u_agen (
    .seg      (code_seg),
    .off      (pf_off),
    .gate_open(a20_open),
    .phys     (mem_req_addr)
  );

  pfq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (flush),
    .push     (push),
    .push_data(mem_rsp_data),
    .pop      (pop),
    .head_data(op_data),
    .count    (q_count)
  );

  assign op_valid = (q_count != '0) && !flush;
  assign pop      = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)     op_ip <= '0;
    else if (flush) op_ip <= flush_ip;
    else if (pop)   op_ip <= op_ip + 1'b1;
  end

  // R5
  ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(op_valid && op_ready)) |=> $stable(op_ip));
  // R6
  ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && op_valid && op_ready) |=> (op_ip == $past(op_ip) + 1'b1));
  // R3
  ip_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (op_ip == $past(flush_ip)));
endmodule

// File: tb/seg_prefetch_unit_bench.sv
module seg_prefetch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] code_seg = '0;
  logic        a20_open = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] flush_ip = '0;
  logic        fetch_ok = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [20:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [7:0]  mem_rsp_data;
  logic        op_valid;
  logic        op_ready = 1'b0;
  logic [7:0]  op_data;
  logic [15:0] op_ip;

  int tests = 0;
  int fails = 0;
  int acc_cnt = 0;

  always #10 clk = ~clk;

  seg_prefetch_unit u_seg_prefetch_unit (
    .clk(clk), .rst_n(rst_n), .code_seg(code_seg), .a20_open(a20_open),
    .flush(flush), .flush_ip(flush_ip), .fetch_ok(fetch_ok),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .op_valid(op_valid), .op_ready(op_ready),
    .op_data(op_data), .op_ip(op_ip)
  );

  function automatic logic [7:0] mdat(input logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]};
  endfunction

  function automatic logic [20:0] xaddr(input logic [15:0] cs, input logic [15:0] off,
                                        input logic gate);
    logic [20:0] s;
    s = {1'b0, cs, 4'b0000} + {5'b0, off};
    if (!gate) s[20] = 1'b0;
    return s;
  endfunction

  // memory model: two-stage latency after acceptance
  logic        st_a_v, st_b_v;
  logic [20:0] st_a_ad, st_b_ad;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_a_v <= 1'b0; st_b_v <= 1'b0; st_a_ad <= '0; st_b_ad <= '0;
    end else begin
      st_a_v  <= mem_req_valid && mem_req_ready;
      st_a_ad <= mem_req_addr;
      st_b_v  <= st_a_v;
      st_b_ad <= st_a_ad;
      if (mem_req_valid && mem_req_ready) acc_cnt <= acc_cnt + 1;
    end
  end
  assign mem_rsp_valid = st_b_v;
  assign mem_rsp_data  = mdat(st_b_ad);

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_flush(input logic [15:0] cs, input logic gate, input logic [15:0] ip);
    @(negedge clk);
    code_seg = cs; a20_open = gate; flush = 1'b1; flush_ip = ip;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic pop_chk(input logic [15:0] exp_ip, input logic [7:0] exp_d, input string req);
    int t;
    @(negedge clk);
    op_ready = 1'b1;
    t = 0;
    while (!op_valid && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(op_valid, req, {31'b0, op_valid}, 32'd1);
    chk(op_data == exp_d, req, {24'b0, op_data}, {24'b0, exp_d});
    chk(op_ip == exp_ip, req, {16'b0, op_ip}, {16'b0, exp_ip});
    @(negedge clk);
    op_ready = 1'b0;
  endtask

  // vector: code segment, start ip, gate, byte count
  localparam logic [36:0] VEC [6] = '{
    {16'h1234, 16'h0100, 1'b1, 4'd5},
    {16'h1000, 16'hFFFD, 1'b1, 4'd6},   // R2 wrap inside segment
    {16'hFFFF, 16'h000E, 1'b1, 4'd4},   // R1 bit 20 passes
    {16'hFFFF, 16'h000E, 1'b0, 4'd4},   // R1 bit 20 forced low
    {16'h0000, 16'hFFFF, 1'b0, 4'd3},   // R2 pointer wrap
    {16'hB800, 16'h7FF0, 1'b1, 4'd8}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int snap;
    logic [15:0] ip0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, permit low: R4 R5
    chk(!op_valid, "R5 reset empty", {31'b0, op_valid}, 0);
    chk(!mem_req_valid, "R4 no read without permit", {31'b0, mem_req_valid}, 0);
    chk(op_ip == 16'h0, "R3 reset ip", {16'b0, op_ip}, 0);

    // vector table walk: R1 R2 R6
    foreach (VEC[v]) begin
      do_flush(VEC[v][36:21], VEC[v][4], VEC[v][20:5]);
      fetch_ok = 1'b1;
      for (int k = 0; k < int'(VEC[v][3:0]); k++) begin
        ip0 = VEC[v][20:5] + 16'(k);
        pop_chk(ip0, mdat(xaddr(VEC[v][36:21], ip0, VEC[v][4])), "R1/R2/R6 vector");
      end
    end

    // permit low: R4 and empty stall R5
    fetch_ok = 1'b0;
    do_flush(16'h2000, 1'b1, 16'h0040);
    snap = acc_cnt;
    op_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk(acc_cnt == snap, "R4 reads while blocked", acc_cnt, snap);
    chk(!op_valid, "R5 empty pop stalls", {31'b0, op_valid}, 0);
    chk(op_ip == 16'h0040, "R5 ip held on stall", {16'b0, op_ip}, 32'h40);
    op_ready = 1'b0;

    // back-pressure: request stays, address correct R1
    mem_req_ready = 1'b0;
    fetch_ok = 1'b1;
    repeat (10) @(negedge clk);
    chk(mem_req_valid, "R1 request waits for ready", {31'b0, mem_req_valid}, 1);
    chk(mem_req_addr == xaddr(16'h2000, 16'h0040, 1'b1), "R1 request address",
        {11'b0, mem_req_addr}, {11'b0, xaddr(16'h2000, 16'h0040, 1'b1)});
    mem_req_ready = 1'b1;

    // depth limit R7
    repeat (40) @(negedge clk);
    chk(acc_cnt - snap == 6, "R7 reads issued to fill", acc_cnt - snap, 6);
    chk(!mem_req_valid, "R7 no read when full", {31'b0, mem_req_valid}, 0);
    for (int k = 0; k < 6; k++)
      pop_chk(16'h0040 + 16'(k), mdat(xaddr(16'h2000, 16'h0040 + 16'(k), 1'b1)), "R7 full queue order");

    // flush with a read in flight: R8
    fetch_ok = 1'b0;
    do_flush(16'h3000, 1'b1, 16'h0010);
    @(negedge clk);
    fetch_ok = 1'b1;
    @(negedge clk);   // accept happened at the edge just passed
    fetch_ok = 1'b0;
    code_seg = 16'h4000; flush = 1'b1; flush_ip = 16'h0200;
    @(negedge clk);
    flush = 1'b0;
    repeat (6) @(negedge clk);
    chk(!op_valid, "R8 stale byte discarded", {31'b0, op_valid}, 0);
    fetch_ok = 1'b1;
    pop_chk(16'h0200, mdat(xaddr(16'h4000, 16'h0200, 1'b1)), "R8 first byte after flush");

    // flush and pop in same cycle: R9
    repeat (20) @(negedge clk);
    op_ready = 1'b1;
    flush = 1'b1; flush_ip = 16'h0300;
    #1;
    chk(!op_valid, "R9 no valid during flush", {31'b0, op_valid}, 0);
    @(negedge clk);
    flush = 1'b0; op_ready = 1'b0;
    chk(op_ip == 16'h0300, "R9 ip not advanced", {16'b0, op_ip}, 32'h300);
    pop_chk(16'h0300, mdat(xaddr(16'h4000, 16'h0300, 1'b1)), "R3 reload after flush");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule